// File: doc/BRIEF.md
# Second-Aligned Block Framer

This block turns a stream of sample-valid strobes into fixed-length blocks. It marks the first and last valid sample of every block and stamps each block with a block sequence number. The count begins at a value loaded when the stream is started.

Once per second of samples, the block raises a sync strobe on the first sample of a block. The sync is not tied to a fixed number of blocks. The number of samples per second need not be a multiple of the block length. So the sync lands on the first block that begins at or after each whole-second sample index, and this keeps it on the true one-second grid over any span of time. As a result, consecutive intervals hold either floor(S/L) or floor(S/L)+1 blocks, in a pattern that repeats. The length of the interval that has just begun is reported on an output.

The block is placed at the head of a block-based signal chain, directly after sample capture. The chain runs continuously once it is started, and a new start pulse re-bases both the timestamp and the second grid.

Top module: `sec_block_framer`

## Requirements
- R1: After reset and before the first start pulse, no sop, eop or sync strobe is raised whatever in_valid does, out_bsn reads 0 and out_blocks reads 0.
- R2: A start pulse loads start_bsn as the timestamp of the first block. An in_valid raised in the same cycle as start is ignored. The first valid sample after start carries sop and sync, with out_bsn equal to the loaded value.
- R3: With L = BLOCK_LEN, counting valid samples from 0 since start, sample i raises out_sop when i mod L = 0 and out_eop when i mod L = L-1. Cycles with in_valid low raise no strobe and do not advance the position.
- R4: out_bsn holds the current block's timestamp throughout the block, in valid and idle cycles alike. It rises by exactly 1 in the cycle after each eop.
- R5: With S = SAMPLES_PER_SEC, block k (its first sample has index k*L) raises out_sync on its sop exactly when k = 0 or floor(k*L/S) differs from floor((k-1)*L/S). This is the first block starting at or after each multiple of S.
- R6: The interval that begins at sync block k with s = floor(k*L/S) contains ceil((s+1)*S/L) - k blocks. That is floor(S/L) or floor(S/L)+1, and is exactly S/L when L divides S.
- R7: out_blocks takes the length of the newly begun interval in the cycle after its sync and holds it until the cycle after the next sync. A start pulse clears it to 0.
- R8: A start pulse during a stream abandons the partial block in progress. Sample counting, the second grid and the timestamp all restart from the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that (re)starts framing |
| start_bsn | input | BSN_W | Timestamp of the first block, sampled with start |
| in_valid | input | 1 | Sample-valid strobe, one sample per high cycle |
| out_sop | output | 1 | First valid sample of a block |
| out_eop | output | 1 | Last valid sample of a block |
| out_sync | output | 1 | First sample of the first block of a one-second interval |
| out_bsn | output | BSN_W | Timestamp of the current block |
| out_blocks | output | clog2(S/L+2) | Block count of the interval in progress |

## Verification
A wrong sample position shows up at once as a sop or eop on the wrong valid sample, within one block of the fault. A wrong remainder or countdown is quieter, because only the placement of the next sync and the next out_blocks value reveal it. That can be up to one full interval later, and a remainder error may need several intervals before the extra-block pattern breaks. For this reason the stimulus runs a full repeat period of the pattern, so that every remainder value is reached and checked against the closed-form sync positions. A timestamp fault appears at the first eop.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

   // width of a counter that must hold values 0 .. sps/len + 1
   function automatic int cnt_w(input int sps, input int len);
      return $clog2(sps / len + 2);
   endfunction

   typedef struct packed {
      logic sop;
      logic eop;
      logic sync;
   } sbf_strobe_t;

endpackage

// File: rtl/sbf_word_ctr.sv
module sbf_word_ctr #(
   parameter int BLOCK_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic first_word,
   output logic last_word
);
   localparam int WW = $clog2(BLOCK_LEN);
   localparam logic [WW-1:0] LAST_V = WW'(BLOCK_LEN - 1);

   logic [WW-1:0] pos_q;

   assign first_word = (pos_q == '0);
   assign last_word  = (pos_q == LAST_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pos_q <= '0;
      else if (clr)      pos_q <= '0;
      else if (adv)      pos_q <= last_word ? '0 : pos_q + 1'b1;
   end

   // R3: position never leaves the block
   p_pos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= LAST_V);

   // R8: a clear puts the next sample at the block head
   p_clr_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> first_word);
endmodule

// File: rtl/sbf_bsn_ctr.sv
module sbf_bsn_ctr #(
   parameter int BSN_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [BSN_W-1:0] load_val,
   input  logic             inc,
   output logic [BSN_W-1:0] bsn
);
   logic [BSN_W-1:0] bsn_q;

   assign bsn = bsn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bsn_q <= '0;
      else if (load)  bsn_q <= load_val;
      else if (inc)   bsn_q <= bsn_q + 1'b1;
   end

   // R4: without an increment request the stamp is frozen
   p_bsn_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !inc) |=> $stable(bsn_q));
endmodule

// File: rtl/sbf_interval_sched.sv
module sbf_interval_sched #(
   parameter int SAMPLES_PER_SEC = 2008,
   parameter int BLOCK_LEN       = 16
) (
   input  logic                                               clk,
   input  logic                                               rst_n,
   input  logic                                               clr,
   input  logic                                               blk_start,
   output logic                                               sync,
   output logic [sbf_pkg::cnt_w(SAMPLES_PER_SEC,BLOCK_LEN)-1:0] blocks
);
   localparam int BASE_N = SAMPLES_PER_SEC / BLOCK_LEN;
   localparam int FRAC_R = SAMPLES_PER_SEC % BLOCK_LEN;
   localparam int BW     = sbf_pkg::cnt_w(SAMPLES_PER_SEC, BLOCK_LEN);
   localparam logic [BW-1:0] BASE_V = BW'(BASE_N);

   logic [BW-1:0] left_q;
   logic [BW-1:0] blocks_q;
   logic          extra;

   assign sync   = blk_start && (left_q == '0);
   assign blocks = blocks_q;

   generate
      if (FRAC_R == 0) begin : g_exact
         assign extra = 1'b0;
      end else begin : g_frac
         localparam int CW = $clog2(BLOCK_LEN) + 1;
         localparam logic [CW-1:0] R_V = CW'(FRAC_R);
         localparam logic [CW-1:0] L_V = CW'(BLOCK_LEN);
         // overshoot of the current sync block past its second boundary
         logic [CW-1:0] over_q;

         assign extra = (R_V > over_q);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     over_q <= '0;
            else if (clr)   over_q <= '0;
            else if (sync)  over_q <= extra ? over_q + L_V - R_V : over_q - R_V;
         end

         // R6: overshoot stays below one block
         p_over_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
            over_q < L_V);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q   <= '0;
         blocks_q <= '0;
      end else if (clr) begin
         left_q   <= '0;
         blocks_q <= '0;
      end else if (sync) begin
         left_q   <= BASE_V - 1'b1 + BW'(extra);
         blocks_q <= BASE_V + BW'(extra);
      end else if (blk_start) begin
         left_q   <= left_q - 1'b1;
      end
   end

   // R6: a reported length is base or base plus one
   p_len_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (blocks_q != '0) |-> (blocks_q == BASE_V || blocks_q == BASE_V + 1'b1));

   // R5: each non-sync block counts down the remaining blocks
   p_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_start && !sync && !clr) |=> left_q == $past(left_q) - 1'b1);
endmodule

// File: rtl/sec_block_framer.sv
module sec_block_framer
   import sbf_pkg::*;
#(
   parameter int SAMPLES_PER_SEC = 2008,
   parameter int BLOCK_LEN       = 16,
   parameter int BSN_W           = 48
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          start,
   input  logic [BSN_W-1:0]                              start_bsn,
   input  logic                                          in_valid,
   output logic                                          out_sop,
   output logic                                          out_eop,
   output logic                                          out_sync,
   output logic [BSN_W-1:0]                              out_bsn,
   output logic [cnt_w(SAMPLES_PER_SEC,BLOCK_LEN)-1:0]   out_blocks
);
   generate
      if (BLOCK_LEN < 2) begin : g_bad_len
         $error("BLOCK_LEN must be at least 2");
      end
      if (SAMPLES_PER_SEC < 2 * BLOCK_LEN) begin : g_bad_sps
         $error("SAMPLES_PER_SEC must cover at least two blocks");
      end
      if (BSN_W < 2) begin : g_bad_bsn
         $error("BSN_W must be at least 2");
      end
   endgenerate

   logic        armed_q;
   logic        eff_valid;
   logic        first_word, last_word;
   logic        sync_w;
   sbf_strobe_t strb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     armed_q <= 1'b0;
      else if (start) armed_q <= 1'b1;
   end

   assign eff_valid = in_valid && armed_q && !start;

   sbf_word_ctr #(.BLOCK_LEN(BLOCK_LEN)) u_word (
      .clk(clk), .rst_n(rst_n), .clr(start), .adv(eff_valid),
      .first_word(first_word), .last_word(last_word));

   sbf_interval_sched #(.SAMPLES_PER_SEC(SAMPLES_PER_SEC), .BLOCK_LEN(BLOCK_LEN)) u_sched (
      .clk(clk), .rst_n(rst_n), .clr(start),
      .blk_start(eff_valid && first_word),
      .sync(sync_w), .blocks(out_blocks));

   always_comb begin
      strb.sop  = eff_valid && first_word;
      strb.eop  = eff_valid && last_word;
      strb.sync = sync_w;
   end

   sbf_bsn_ctr #(.BSN_W(BSN_W)) u_bsn (
      .clk(clk), .rst_n(rst_n), .load(start), .load_val(start_bsn),
      .inc(strb.eop), .bsn(out_bsn));

   assign out_sop  = strb.sop;
   assign out_eop  = strb.eop;
   assign out_sync = strb.sync;

   // R5: sync only ever rides on a block head
   p_sync_on_sop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_sync |-> out_sop);

   // R1: nothing is framed before the first start
   p_idle_unarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |-> !(out_sop || out_eop || out_sync));

   // R4: each block end steps the stamp by one
   p_bsn_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_eop && !start) |=> out_bsn == $past(out_bsn) + 1'b1);

   // R2: start loads the first timestamp
   p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> out_bsn == $past(start_bsn));

   // R3: two block ends can never be adjacent
   p_no_double_eop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_eop |=> !out_eop);
endmodule

// File: tb/sec_block_framer_bench.sv
module sec_block_framer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int S     = 100;
   localparam int L     = 7;
   localparam int BSN_W = 40;
   localparam int BW    = $clog2(S / L + 2);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [BSN_W-1:0] start_bsn = '0;
   logic             in_valid = 1'b0;
   logic             out_sop, out_eop, out_sync;
   logic [BSN_W-1:0] out_bsn;
   logic [BW-1:0]    out_blocks;

   int n_run  = 0;
   int n_fail = 0;

   // bench model
   bit     armed = 0;
   longint idx = 0;
   longint bsn0 = 0;
   longint exp_blocks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sec_block_framer #(.SAMPLES_PER_SEC(S), .BLOCK_LEN(L), .BSN_W(BSN_W)) u_sec_block_framer (
      .clk(clk), .rst_n(rst_n), .start(start), .start_bsn(start_bsn),
      .in_valid(in_valid), .out_sop(out_sop), .out_eop(out_eop),
      .out_sync(out_sync), .out_bsn(out_bsn), .out_blocks(out_blocks));

   task automatic check(input string req, input longint act, input longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit is_sync_blk(input longint k);
      if (k == 0) return 1;
      return ((k * L) / S) != (((k - 1) * L) / S);
   endfunction

   function automatic longint interval_len(input longint k);
      longint s;
      s = (k * L) / S;
      return ((s + 1) * S + L - 1) / L - k;
   endfunction

   // one cycle of stimulus with full output comparison
   task automatic step(input bit v, input bit st, input longint sb);
      bit     live, e_sop, e_eop, e_sync;
      longint k, pos;
      @(negedge clk);
      in_valid  = v;
      start     = st;
      start_bsn = BSN_W'(sb);
      #(CLK_PERIOD/4);
      k     = idx / L;
      pos   = idx % L;
      live  = armed && v && !st;
      e_sop = live && (pos == 0);
      e_eop = live && (pos == L - 1);
      e_sync = e_sop && is_sync_blk(k);
      check(st ? "R2 sop" : "R3 sop", out_sop, e_sop);
      check("R3 eop", out_eop, e_eop);
      check("R5 sync", out_sync, e_sync);
      check("R7 blocks", out_blocks, exp_blocks);
      if (!armed)
         check("R1 bsn", out_bsn, 0);
      else if (!st)
         check("R4 bsn", out_bsn, bsn0 + k);
      if (st) begin
         armed = 1; idx = 0; bsn0 = sb; exp_blocks = 0;
      end else if (live) begin
         if (e_sync) exp_blocks = interval_len(k);
         idx++;
      end
   endtask

   task automatic t_pre_start;   // R1
      for (int i = 0; i < 20; i++) step(i % 2, 0, 0);
   endtask

   task automatic t_start_same_cycle;   // R2
      step(1, 1, 64'h12_3456_7000);
      check("R2 first sync", 0, 0);
      step(1, 0, 0);   // first counted sample: sop, sync, loaded stamp
   endtask

   task automatic t_dense;   // R3..R7, a full 7 s repeat of the pattern
      for (int i = 0; i < 760; i++) step(1, 0, 0);
      check("R6 seven seconds", idx / L >= 100, 1);
   endtask

   task automatic t_gappy;   // R3, R4 idle cycles hold position and stamp
      for (int i = 0; i < 300; i++) step(i % 3 != 1, 0, 0);
   endtask

   task automatic t_restart;   // R8 mid-block restart
      for (int i = 0; i < 40; i++) step(1, 0, 0);
      step(0, 1, 64'h55);
      step(0, 0, 0);
      check("R8 cleared blocks", out_blocks, 0);
      for (int i = 0; i < 230; i++) step(i % 5 != 4, 0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 3);
      @(negedge clk);
      check("R1 reset sop", out_sop, 0);
      check("R1 reset blocks", out_blocks, 0);
      rst_n = 1'b1;
      t_pre_start();
      t_start_same_cycle();
      t_dense();
      t_gappy();
      t_restart();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule